// File: doc/BRIEF.md
# Supply Undervoltage Monitor Controller

This block is the digital side of a supply-voltage supervisor. Two analog comparators drive it asynchronously. One reports that the supply has dropped below the lower (falling) threshold. The other reports that the supply has climbed above the upper (rising) threshold. After synchronizing both, the block keeps a hysteretic low-supply status bit. It raises an interrupt flag each time that bit changes. It can also request a chip reset, which holds until the supply has recovered past the upper threshold.

Software reaches the block through one 8-bit register. The fields are:

| Bit | Access | Meaning |
|-----|--------|---------|
| 0 | read-only | low-supply status |
| 1 | read-only | change flag |
| 2 | read/write | interrupt enable |
| 3 | write-one | acknowledge (reads as 0) |
| 4 | read/write | monitor off |
| 5 | read/write | reset disable |

Bits 7:6 read as 0. In polled or interrupt-driven use, software sets the reset-disable bit. For supervisory use, software clears it so that a supply drop forces a reset.

Top module: `lvmon_ctrl`

## Requirements
- R1: Each comparator input passes through SYNC_STAGES flip-flops. With the default of 2, a change on an input shows on the status bit (bit 0) after the third rising clock edge, counted from the edge after the input changes.
- R2: While the monitor is on, the status bit is set when the falling-threshold input is 1. It is cleared when the falling input is 0 and the rising-threshold input is 1. When both inputs are 0, the status bit keeps its value.
- R3: The change flag (bit 1) is set at the same edge as any change of the status bit, in either direction.
- R4: `irq_o` is 1 exactly when the change flag is 1, the interrupt enable (bit 2) is 1, and no reset is being requested.
- R5: A register write with bit 3 set clears the change flag. A write with bit 3 clear leaves the flag unchanged. Bit 3 always reads as 0.
- R6: If a status change and a write-one acknowledge fall in the same cycle, the change flag stays set.
- R7: While the monitor-off bit (bit 4) is 1, the status bit does not change, no flag is set and `lv_reset_o` stays 0.
- R8: With the monitor on and reset disable (bit 5) at 0, a synchronized falling-threshold input sets `lv_reset_o` and clears the interrupt enable at the same edge.
- R9: Once set, `lv_reset_o` stays 1 until the rising-threshold input is seen as 1, even after the falling-threshold input returns to 0.
- R10: While reset disable is 1, `lv_reset_o` stays 0 whatever the comparators report.
- R11: After `rst_n` the register reads with monitor-off equal to CFG_OFF_INIT, reset-disable equal to CFG_RDIS_INIT, and every other bit 0. `irq_o` and `lv_reset_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_below_fall_i | input | 1 | Asynchronous comparator: supply below falling threshold |
| cmp_above_rise_i | input | 1 | Asynchronous comparator: supply above rising threshold |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | REG_W | Register write data |
| reg_rdata_o | output | REG_W | Register read data |
| irq_o | output | 1 | Interrupt request |
| lv_reset_o | output | 1 | Reset request to the reset sequencer |

## Verification
The bench builds the block with SYNC_STAGES=2, CFG_OFF_INIT=0 and CFG_RDIS_INIT=1. Because reset is disabled at start, the first scenarios can walk the hysteresis band, the flag-and-acknowledge path and the collision of a status change with an acknowledge, without a reset cutting them short. Reset generation is then turned on by a register write, so the forced-reset hold and the clearing of the interrupt enable are both reached from a known non-default configuration. Keeping two synchronizer stages makes the three-edge latency exact, so the bench can write into the cycle where the status changes.

// File: rtl/lvmon_pkg.sv
package lvmon_pkg;
    localparam int unsigned BIT_STAT = 0;
    localparam int unsigned BIT_FLAG = 1;
    localparam int unsigned BIT_IEN  = 2;
    localparam int unsigned BIT_ACK  = 3;
    localparam int unsigned BIT_OFF  = 4;
    localparam int unsigned BIT_RDIS = 5;
    localparam int unsigned MIN_REG_W = 6;

    typedef struct packed {
        logic status;
        logic rst;
    } hyst_st_t;

    typedef struct packed {
        logic flag;
        logic ien;
        logic off;
        logic rdis;
    } reg_st_t;
endpackage

// File: rtl/lvmon_sync.sv
module lvmon_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] sh_d, sh_q;

        if (STAGES == 1) begin : g_one
            always_comb sh_d = d_i[b];
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], d_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end

        assign q_o[b] = sh_q[STAGES-1];
    end
endmodule

// File: rtl/lvmon_hyst.sv
module lvmon_hyst
    import lvmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic below_fall_i,
    input  logic above_rise_i,
    input  logic enable_i,
    input  logic rst_en_i,
    output logic status_o,
    output logic rst_o,
    output logic toggle_o,
    output logic rst_nxt_o
);
    hyst_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (enable_i) begin
            if (below_fall_i)      st_d.status = 1'b1;
            else if (above_rise_i) st_d.status = 1'b0;
        end
        st_d.rst = enable_i & rst_en_i & (below_fall_i | (st_q.rst & ~above_rise_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o  = st_q.status;
    assign rst_o     = st_q.rst;
    assign toggle_o  = st_d.status ^ st_q.status;
    assign rst_nxt_o = st_d.rst;
endmodule

// File: rtl/lvmon_regfile.sv
module lvmon_regfile
    import lvmon_pkg::*;
#(
    parameter int unsigned REG_W     = 8,
    parameter bit          OFF_INIT  = 1'b0,
    parameter bit          RDIS_INIT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             toggle_i,
    input  logic             rst_nxt_i,
    input  logic             status_i,
    input  logic             rst_i,
    output logic             off_o,
    output logic             rdis_o,
    output logic             irq_o,
    output logic [REG_W-1:0] rdata_o
);
    reg_st_t r_d, r_q;
    logic    ack;

    always_comb begin
        r_d = r_q;
        ack = wr_i & wdata_i[BIT_ACK];
        if (wr_i) begin
            r_d.ien  = wdata_i[BIT_IEN];
            r_d.off  = wdata_i[BIT_OFF];
            r_d.rdis = wdata_i[BIT_RDIS];
        end
        if (rst_nxt_i) r_d.ien = 1'b0;
        if (toggle_i)  r_d.flag = 1'b1;
        else if (ack)  r_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.flag <= 1'b0;
            r_q.ien  <= 1'b0;
            r_q.off  <= OFF_INIT;
            r_q.rdis <= RDIS_INIT;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o           = '0;
        rdata_o[BIT_STAT] = status_i;
        rdata_o[BIT_FLAG] = r_q.flag;
        rdata_o[BIT_IEN]  = r_q.ien;
        rdata_o[BIT_OFF]  = r_q.off;
        rdata_o[BIT_RDIS] = r_q.rdis;
    end

    assign off_o  = r_q.off;
    assign rdis_o = r_q.rdis;
    assign irq_o  = r_q.flag & r_q.ien & ~rst_i;
endmodule

// File: rtl/lvmon_ctrl.sv
module lvmon_ctrl
    import lvmon_pkg::*;
#(
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned REG_W         = 8,
    parameter bit          CFG_OFF_INIT  = 1'b0,
    parameter bit          CFG_RDIS_INIT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_below_fall_i,
    input  logic             cmp_above_rise_i,
    input  logic             reg_wr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             irq_o,
    output logic             lv_reset_o
);
    localparam int unsigned N_CMP = 2;

    logic [N_CMP-1:0] cmp_s;
    logic status, rst_q, toggle, rst_nxt, off, rdis;

    lvmon_sync #(.STAGES(SYNC_STAGES), .WIDTH(N_CMP)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cmp_above_rise_i, cmp_below_fall_i}),
        .q_o   (cmp_s)
    );

    lvmon_hyst hyst_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .below_fall_i (cmp_s[0]),
        .above_rise_i (cmp_s[1]),
        .enable_i     (~off),
        .rst_en_i     (~rdis),
        .status_o     (status),
        .rst_o        (rst_q),
        .toggle_o     (toggle),
        .rst_nxt_o    (rst_nxt)
    );

    lvmon_regfile #(
        .REG_W     (REG_W),
        .OFF_INIT  (CFG_OFF_INIT),
        .RDIS_INIT (CFG_RDIS_INIT)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr_i),
        .wdata_i   (reg_wdata_i),
        .toggle_i  (toggle),
        .rst_nxt_i (rst_nxt),
        .status_i  (status),
        .rst_i     (rst_q),
        .off_o     (off),
        .rdis_o    (rdis),
        .irq_o     (irq_o),
        .rdata_o   (reg_rdata_o)
    );

    assign lv_reset_o = rst_q;
endmodule

// File: rtl/lvmon_chk.sv
module lvmon_chk
    import lvmon_pkg::*;
#(
    parameter int unsigned REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] reg_rdata_o,
    input logic             irq_o,
    input logic             lv_reset_o
);
    AST_IRQ_NEEDS_FLAG_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (reg_rdata_o[BIT_FLAG] && reg_rdata_o[BIT_IEN])); // R4
    AST_RESET_MASKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        lv_reset_o |-> !irq_o); // R4
    AST_RESET_DROPS_IEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lv_reset_o) |-> !reg_rdata_o[BIT_IEN]); // R8
    AST_CHANGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_rdata_o[BIT_STAT]) |-> reg_rdata_o[BIT_FLAG]); // R3
    AST_OFF_FREEZES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_rdata_o[BIT_OFF]) |-> $stable(reg_rdata_o[BIT_STAT])); // R7
    AST_OFF_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_rdata_o[BIT_OFF]) |-> !lv_reset_o); // R7
    AST_RDIS_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_rdata_o[BIT_RDIS]) |-> !lv_reset_o); // R10
endmodule

bind lvmon_ctrl lvmon_chk #(.REG_W(REG_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .lv_reset_o  (lv_reset_o)
);

// File: tb/lvmon_ctrl_tb_top.sv
`timescale 1ns/1ps
module lvmon_ctrl_tb_top;
    localparam int unsigned REG_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fall = 1'b0;
    logic rise = 1'b0;
    logic wr = 1'b0;
    logic [REG_W-1:0] wdata = '0;
    logic [REG_W-1:0] rdata;
    logic irq, lvr;

    int vectors = 0;
    int fails = 0;

    always #5 clk = ~clk;

    lvmon_ctrl #(
        .SYNC_STAGES   (2),
        .REG_W         (REG_W),
        .CFG_OFF_INIT  (1'b0),
        .CFG_RDIS_INIT (1'b1)
    ) dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .cmp_below_fall_i (fall),
        .cmp_above_rise_i (rise),
        .reg_wr_i         (wr),
        .reg_wdata_i      (wdata),
        .reg_rdata_o      (rdata),
        .irq_o            (irq),
        .lv_reset_o       (lvr)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_cmp(input logic f, input logic r);
        @(negedge clk);
        fall = f;
        rise = r;
    endtask

    task automatic reg_write(input logic [REG_W-1:0] v);
        @(negedge clk);
        wr = 1'b1;
        wdata = v;
        @(posedge clk);
        #1;
        wr = 1'b0;
        wdata = '0;
    endtask

    task automatic t_reset_state;
        chk("R11", "register after reset", rdata, 32'h20);
        chk("R11", "irq after reset", irq, 0);
        chk("R11", "reset req after reset", lvr, 0);
    endtask

    task automatic t_latency;
        set_cmp(1'b1, 1'b0);
        edges(2);
        chk("R1", "status after two edges", rdata[0], 0);
        edges(1);
        chk("R1", "status after third edge", rdata[0], 1);
        chk("R3", "flag on rising status", rdata[1], 1);
        chk("R10", "no reset while disabled", lvr, 0);
    endtask

    task automatic t_hold;
        set_cmp(1'b0, 1'b0);
        edges(4);
        chk("R2", "status held in band", rdata[0], 1);
        reg_write(8'h28);
        chk("R5", "ack clears flag", rdata[1], 0);
        chk("R5", "ack bit reads zero", rdata[3], 0);
        set_cmp(1'b0, 1'b1);
        edges(3);
        chk("R2", "status cleared above rise", rdata[0], 0);
        chk("R3", "flag on falling status", rdata[1], 1);
    endtask

    task automatic t_ack_zero;
        reg_write(8'h20);
        chk("R5", "write-zero ack keeps flag", rdata[1], 1);
        reg_write(8'h28);
        chk("R5", "write-one ack clears flag", rdata[1], 0);
    endtask

    task automatic t_irq;
        reg_write(8'h24);
        chk("R4", "no irq without flag", irq, 0);
        set_cmp(1'b1, 1'b0);
        edges(3);
        chk("R4", "irq with flag and enable", irq, 1);
        reg_write(8'h2C);
        chk("R4", "irq drops after ack", irq, 0);
        reg_write(8'h20);
    endtask

    task automatic t_collide;
        set_cmp(1'b0, 1'b1);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        wr = 1'b1;
        wdata = 8'h28;
        @(posedge clk);
        #1;
        wr = 1'b0;
        wdata = '0;
        chk("R6", "status changed at collision", rdata[0], 0);
        chk("R6", "flag kept at collision", rdata[1], 1);
        reg_write(8'h28);
    endtask

    task automatic t_off;
        reg_write(8'h30);
        set_cmp(1'b1, 1'b0);
        edges(5);
        chk("R7", "status frozen while off", rdata[0], 0);
        chk("R7", "no flag while off", rdata[1], 0);
        chk("R7", "no reset while off", lvr, 0);
        reg_write(8'h20);
        edges(1);
        chk("R7", "status follows once on", rdata[0], 1);
        reg_write(8'h28);
        set_cmp(1'b0, 1'b1);
        edges(3);
        reg_write(8'h28);
    endtask

    task automatic t_force_reset;
        reg_write(8'h04);
        chk("R10", "reset idle before drop", lvr, 0);
        set_cmp(1'b1, 1'b0);
        edges(3);
        chk("R8", "reset asserted", lvr, 1);
        chk("R8", "enable cleared", rdata[2], 0);
        chk("R8", "irq suppressed", irq, 0);
        set_cmp(1'b0, 1'b0);
        edges(5);
        chk("R9", "reset held in band", lvr, 1);
        set_cmp(1'b0, 1'b1);
        edges(2);
        chk("R9", "reset held until sync", lvr, 1);
        edges(1);
        chk("R9", "reset released above rise", lvr, 0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        edges(3);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset_state();
        t_latency();
        t_hold();
        t_ack_zero();
        t_irq();
        t_collide();
        t_off();
        t_force_reset();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule